// File: doc/BRIEF.md
# Entropy Seed Sequence Health Monitor

This block watches the serial output of an entropy source. The source delivers one bit for each sample strobe. The block looks for two degenerate patterns. The first is a run of identical bits that goes on too long. The second is a 0/1 alternation that goes on too long. Two saturating counters track these patterns side by side, and either one raises a seed fault. The block drives a live fault level and a single-cycle pulse when the fault first appears. It also keeps a sticky fault flag, which a clear input resets. An interrupt line is raised when that flag is set and interrupts are enabled.

A small state machine decides when the two counters may be trusted. It has four states:

- `ST_OFF`: the monitor is disabled.
- `ST_PRIME`: the monitor is enabled and has no previous bit yet.
- `ST_TRACK`: the stream is healthy.
- `ST_FAULT`: a limit is exceeded.

Transitions:

- Deasserting the enable forces `ST_OFF` from any state.
- An enabled `ST_OFF` moves to `ST_PRIME`.
- The first accepted sample moves `ST_OFF` or `ST_PRIME` to `ST_TRACK`.
- A sample that pushes either counter past its limit moves `ST_TRACK` to `ST_FAULT`.
- A sample that brings both counters back within their limits moves `ST_FAULT` to `ST_TRACK`.

Top module: `seed_health_monitor`

## Requirements
- R1: Once more than RUN_LIMIT (default 64) consecutive accepted samples carry the same value, 0 or 1, `seed_err` is 1 after the clock edge that accepts the offending sample. With RUN_LIMIT identical samples it stays 0.
- R2: Once more than ALT_LIMIT (default 32) consecutive alternations are seen, `seed_err` is 1. An alternation is an accepted sample that differs from the one before, so 34 alternating bits raise the fault and 33 do not. Two equal consecutive samples restart the alternation count.
- R3: `seed_err_pulse` is 1 for exactly one cycle, raised at the same edge where `seed_err` rises.
- R4: `seed_err_flag` is set at the same edge where the fault is raised. It stays 1 until a cycle with `flag_clr`=1, and it clears at that edge. A set in the same cycle as a clear wins.
- R5: `irq` is 1 exactly when `seed_err_flag` is 1 and `irq_en` is 1.
- R6: `seed_err` returns to 0 at the edge of the accepted sample that brings both counts back within their limits. For a run fault this is a differing bit. For an alternation fault this is an equal bit.
- R7: While `enable` is 0, `seed_err` is 0. Both counts are cleared, and the previous bit is forgotten. After re-enabling, the first sample starts a fresh run.
- R8: Both counts saturate rather than wrap. A degenerate stream of any length keeps `seed_err` at 1 and produces only one pulse.
- R9: Cycles with `smp_stb`=0 leave both counts unchanged.
- R10: After reset, `seed_err`, `seed_err_pulse`, `seed_err_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitor enable; 0 clears the counts |
| smp_stb | input | 1 | Sample strobe; one bit is accepted per cycle where it is high |
| smp_bit | input | 1 | Sampled entropy bit |
| flag_clr | input | 1 | Clears the sticky fault flag |
| irq_en | input | 1 | Interrupt enable |
| seed_err | output | 1 | Live seed fault level |
| seed_err_pulse | output | 1 | One-cycle pulse when the fault first appears |
| seed_err_flag | output | 1 | Sticky fault flag |
| irq | output | 1 | Pending interrupt |

## Verification
Two events can fall in the same clock cycle. One is the flag being raised by a new fault. The other is the flag being cleared by `flag_clr`. The bench provokes this by asserting `flag_clr` together with the strobe of the 65th identical sample. It then checks that the flag is still set, and that the pulse and live level rose at that same edge. The run and alternation counters are also driven concurrently, in patterns where one restarts the other. Each fault is checked at its exact limit sample and one sample earlier.

// File: rtl/seed_mon_pkg.sv
package seed_mon_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_TRACK = 2'd2,
        ST_FAULT = 2'd3
    } mon_state_e;
endpackage

// File: rtl/seed_sat_counter.sv
module seed_sat_counter #(
    parameter int LIMIT       = 64,
    parameter int RESTART_VAL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic restart,
    output logic over_nx
);
    localparam int W = $clog2(LIMIT + 2);
    localparam logic [W-1:0] SAT_VAL = W'(LIMIT + 1);
    localparam logic [W-1:0] LIM_VAL = W'(LIMIT);
    localparam logic [W-1:0] RST_VAL = W'(RESTART_VAL);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (step) begin
            if (restart)
                cnt_d = RST_VAL;
            else if (cnt_q != SAT_VAL)
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign over_nx = (cnt_d > LIM_VAL);
endmodule

// File: rtl/seed_mon_fsm.sv
module seed_mon_fsm
    import seed_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic take,
    input  logic fault_nx,
    input  logic flag_clr,
    output logic have_prev,
    output logic err_level,
    output logic err_pulse,
    output logic err_flag
);
    mon_state_e state_q, state_d;
    logic       pulse_q, flag_q;
    logic       entering_fault;

    always_comb begin
        state_d = state_q;
        if (!enable)
            state_d = ST_OFF;
        else begin
            unique case (state_q)
                ST_OFF, ST_PRIME: state_d = take ? ST_TRACK : ST_PRIME;
                ST_TRACK:         state_d = (take && fault_nx)  ? ST_FAULT : ST_TRACK;
                ST_FAULT:         state_d = (take && !fault_nx) ? ST_TRACK : ST_FAULT;
                default:          state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    assign entering_fault = (state_d == ST_FAULT) && (state_q != ST_FAULT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= entering_fault;
            if (entering_fault)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign have_prev = (state_q == ST_TRACK) || (state_q == ST_FAULT);
    assign err_level = enable && (state_q == ST_FAULT);
    assign err_pulse = pulse_q;
    assign err_flag  = flag_q;
endmodule

// File: rtl/seed_health_monitor.sv
module seed_health_monitor #(
    parameter int RUN_LIMIT = 64,
    parameter int ALT_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic smp_stb,
    input  logic smp_bit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic seed_err,
    output logic seed_err_pulse,
    output logic seed_err_flag,
    output logic irq
);
    logic take, prev_bit_q, same_bit, have_prev;
    logic run_over_nx, alt_over_nx;

    assign take     = enable && smp_stb;
    assign same_bit = (smp_bit == prev_bit_q);

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_bit_q <= 1'b0;
        else if (take)
            prev_bit_q <= smp_bit;
    end

    // identical-value run length, restarts at one on a change
    seed_sat_counter #(.LIMIT(RUN_LIMIT), .RESTART_VAL(1)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!enable),
        .step    (take),
        .restart (!have_prev || !same_bit),
        .over_nx (run_over_nx)
    );

    // alternation count, restarts at zero on a repeated value
    seed_sat_counter #(.LIMIT(ALT_LIMIT), .RESTART_VAL(0)) u_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!enable),
        .step    (take),
        .restart (!have_prev || same_bit),
        .over_nx (alt_over_nx)
    );

    seed_mon_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .take      (take),
        .fault_nx  (run_over_nx || alt_over_nx),
        .flag_clr  (flag_clr),
        .have_prev (have_prev),
        .err_level (seed_err),
        .err_pulse (seed_err_pulse),
        .err_flag  (seed_err_flag)
    );

    assign irq = seed_err_flag && irq_en;
endmodule

// File: rtl/seed_health_monitor_chk.sv
module seed_health_monitor_chk #(
    parameter int RUN_LIMIT = 64,
    parameter int ALT_LIMIT = 32
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic smp_stb,
    input logic smp_bit,
    input logic flag_clr,
    input logic irq_en,
    input logic seed_err,
    input logic seed_err_pulse,
    input logic seed_err_flag,
    input logic irq
);
    // independent shadow of the stream statistics
    int   run_sh, alt_sh;
    logic prev_sh, valid_sh;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_sh   <= 0;
            alt_sh   <= 0;
            prev_sh  <= 1'b0;
            valid_sh <= 1'b0;
        end else if (smp_stb) begin
            prev_sh  <= smp_bit;
            valid_sh <= 1'b1;
            if (!valid_sh) begin
                run_sh <= 1;
                alt_sh <= 0;
            end else if (smp_bit == prev_sh) begin
                run_sh <= (run_sh < 1000) ? run_sh + 1 : run_sh;
                alt_sh <= 0;
            end else begin
                run_sh <= 1;
                alt_sh <= (alt_sh < 1000) ? alt_sh + 1 : alt_sh;
            end
        end
    end

    p_run_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && run_sh > RUN_LIMIT) |-> seed_err);

    p_alt_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && alt_sh > ALT_LIMIT) |-> seed_err);

    p_healthy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sh <= RUN_LIMIT && alt_sh <= ALT_LIMIT) |-> !seed_err);

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err_pulse |=> !seed_err_pulse);

    p_pulse_with_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_err_pulse && enable) |-> seed_err);

    p_flag_on_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err_pulse |-> seed_err_flag);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_err_flag && !flag_clr) |=> seed_err_flag);

    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && seed_err_flag));

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !seed_err);
endmodule

bind seed_health_monitor seed_health_monitor_chk #(
    .RUN_LIMIT(RUN_LIMIT),
    .ALT_LIMIT(ALT_LIMIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .smp_stb        (smp_stb),
    .smp_bit        (smp_bit),
    .flag_clr       (flag_clr),
    .irq_en         (irq_en),
    .seed_err       (seed_err),
    .seed_err_pulse (seed_err_pulse),
    .seed_err_flag  (seed_err_flag),
    .irq            (irq)
);

// File: tb/tb_seed_health_monitor.sv
`timescale 1ns/1ps
module tb_seed_health_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, smp_stb = 1'b0, smp_bit = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
    logic seed_err, seed_err_pulse, seed_err_flag, irq;
    int   n_checks = 0, n_errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    seed_health_monitor dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_stb(smp_stb),
        .smp_bit(smp_bit), .flag_clr(flag_clr), .irq_en(irq_en),
        .seed_err(seed_err), .seed_err_pulse(seed_err_pulse),
        .seed_err_flag(seed_err_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one accepted sample; returns at the negedge after the accepting edge
    task automatic send(input logic b, input logic clr = 1'b0);
        @(negedge clk);
        smp_stb = 1'b1; smp_bit = b; flag_clr = clr;
        @(negedge clk);
        smp_stb = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic send_n(input logic b, input int n);
        for (int i = 0; i < n; i++) send(b);
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic restart_mon();
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
    endtask

    task automatic t_reset();
        chk("R10 level", seed_err, 1'b0);
        chk("R10 pulse", seed_err_pulse, 1'b0);
        chk("R10 flag", seed_err_flag, 1'b0);
        chk("R10 irq", irq, 1'b0);
    endtask

    task automatic t_run_limit();
        restart_mon();
        send_n(1'b0, 64);
        chk("R1 64 equal no fault", seed_err, 1'b0);
        send(1'b0);
        chk("R1 65th equal faults", seed_err, 1'b1);
        chk("R3 pulse at rise", seed_err_pulse, 1'b1);
        chk("R4 flag set", seed_err_flag, 1'b1);
        chk("R5 irq masked", irq, 1'b0);
        @(negedge clk);
        chk("R3 pulse one cycle", seed_err_pulse, 1'b0);
        irq_en = 1'b1; #1;
        chk("R5 irq enabled", irq, 1'b1);
        send(1'b1);
        chk("R6 differing bit clears level", seed_err, 1'b0);
        chk("R4 flag sticky", seed_err_flag, 1'b1);
        clear_flag();
        chk("R4 flag cleared", seed_err_flag, 1'b0);
        chk("R5 irq follows flag", irq, 1'b0);
        irq_en = 1'b0;
    endtask

    task automatic t_ones_run();
        restart_mon();
        send_n(1'b1, 64);
        chk("R1 64 ones no fault", seed_err, 1'b0);
        send(1'b1);
        chk("R1 65th one faults", seed_err, 1'b1);
        clear_flag();
    endtask

    task automatic t_alt_limit();
        restart_mon();
        for (int i = 0; i < 33; i++) send(logic'(i % 2));
        chk("R2 33 alternating no fault", seed_err, 1'b0);
        send(1'b1);
        chk("R2 34th alternating faults", seed_err, 1'b1);
        chk("R3 pulse on alt fault", seed_err_pulse, 1'b1);
        send(1'b1);
        chk("R6 equal bit clears alt fault", seed_err, 1'b0);
        clear_flag();
    endtask

    task automatic t_alt_broken();
        restart_mon();
        for (int i = 0; i < 20; i++) send(logic'(i % 2));
        send(1'b1);
        for (int i = 0; i < 20; i++) send(logic'((i + 1) % 2 == 0 ? 1 : 0));
        chk("R2 equal pair restarts alternation", seed_err, 1'b0);
    endtask

    task automatic t_disable();
        restart_mon();
        send_n(1'b0, 65);
        chk("R7 fault before disable", seed_err, 1'b1);
        @(negedge clk); enable = 1'b0; #1;
        chk("R7 level zero while disabled", seed_err, 1'b0);
        @(negedge clk); enable = 1'b1;
        send(1'b0);
        chk("R7 fresh run after enable", seed_err, 1'b0);
        send_n(1'b0, 63);
        chk("R7 run counted from one", seed_err, 1'b0);
        send(1'b0);
        chk("R7 65th fresh sample faults", seed_err, 1'b1);
        clear_flag();
    endtask

    task automatic t_saturate();
        int pulses = 0;
        restart_mon();
        for (int i = 0; i < 300; i++) begin
            send(1'b1);
            if (seed_err_pulse) pulses++;
        end
        chk("R8 level held after 300", seed_err, 1'b1);
        n_checks++;
        if (pulses != 1) begin
            n_errors++;
            $display("FAIL R8 pulse count: actual %0d expected 1", pulses);
        end
        clear_flag();
    endtask

    task automatic t_no_strobe();
        restart_mon();
        send_n(1'b0, 64);
        repeat (10) @(negedge clk);
        chk("R9 idle cycles no fault", seed_err, 1'b0);
        send(1'b0);
        chk("R9 count held across idle", seed_err, 1'b1);
        clear_flag();
    endtask

    task automatic t_set_wins();
        restart_mon();
        send_n(1'b0, 64);
        send(1'b0, 1'b1);
        chk("R4 set wins over clear", seed_err_flag, 1'b1);
        chk("R3 level with pulse", seed_err, 1'b1);
        clear_flag();
        chk("R4 later clear works", seed_err_flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_limit();
        t_ones_run();
        t_alt_limit();
        t_alt_broken();
        t_disable();
        t_saturate();
        t_no_strobe();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule